// File: doc/BRIEF.md
# Programmable Interrupt Controller Register Interface

This block is the register side of an eight-input programmable interrupt controller. Software reaches it through a byte-wide port with a single address bit: address 0 is the command address and address 1 is the data address. After reset the block must be configured by a short run of initialization words. The first word goes to the command address. The words after it go to the data address, and flag bits of the first word decide how many of them are expected. Once it is configured, the block reads command-address writes as operational commands: end-of-interrupt and read-back selection. Data-address writes load the interrupt mask.

Request pulses on `irqReq` set bits in the request register, and those bits stay set until they are acknowledged. The block reports whether any unmasked request is waiting. It gives the number of the highest-priority such request, with input 0 highest, and a full vector made of a configured 5-bit base and that number. A one-cycle acknowledge strobe moves the chosen request from the request register into the in-service register. When automatic end of interrupt is configured, the strobe only drops the request. End-of-interrupt commands clear in-service bits. A command-address write with bit 4 set restarts initialization at any time.

Top module: `picRegTop`

## Requirements
- R1: After reset, a command-address read returns 0 (the request register is selected and empty), a data-address read returns 0, `intPending` is 0, and the block expects the first initialization word.
- R2: While the first word is expected, any command-address write is taken as that word and the block then expects the vector-base word. Data-address writes in this state are ignored, so the mask stays unchanged.
- R3: The vector-base word is the next data write. After it, the block expects the cascade word if bit 1 of the first word is 0. If bit 1 is 1 and bit 0 is 1, it expects the mode word. Otherwise it is ready.
- R4: The cascade word is the next data write, after which the block expects the mode word if bit 0 of the first word is 1 and is ready otherwise. The mode word is the next data write, after which the block is ready. Bit 1 of the mode word enables automatic end of interrupt.
- R5: When ready, a data-address write loads the 8-bit mask, and a data-address read returns the mask.
- R6: When ready, a command-address write is decoded on bits 4:3. 00 is an end-of-interrupt/priority command and 01 is a read-select command. Neither changes the mask.
- R7: A command-address read returns the request register when the last read-select bits 1:0 were 10, the in-service register when they were 11, and 0 otherwise. Reset selects 10.
- R8: A pulse on `irqReq[i]` sets request bit i, and the bit stays set until it is acknowledged. `intPending` is 1 exactly when a request bit is set whose mask bit is 0.
- R9: `intNum` is the lowest-numbered unmasked set request, or 0 when none is set. `intVector` is bits 7:3 of the vector-base word followed by `intNum`.
- R10: An `intAck` pulse while `intPending` is 1 clears request bit `intNum`. Without automatic end of interrupt it also sets in-service bit `intNum`; with it, the in-service register is unchanged. An ack with nothing pending has no effect.
- R11: A command with bits 4:3 = 00, bit 5 = 1 and bit 6 = 0 clears the lowest-numbered set in-service bit. With bit 6 = 1 it clears the in-service bit named by bits 2:0. With bit 5 = 0 the in-service register is unchanged.
- R12: A command-address write with bit 4 set, in any state, clears the mask and the in-service register, is taken as the first word, and makes the block expect the vector-base word. The request register and the read select are kept. A command write with bit 4 clear while a data word is expected is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| regAddr | input | 1 | 0 = command address, 1 = data address (reads and writes) |
| wrEn | input | 1 | Write strobe for one cycle |
| wrData | input | 8 | Write byte |
| rdData | output | 8 | Read byte for `regAddr`, combinational |
| irqReq | input | 8 | Request pulses, one bit per input |
| intAck | input | 1 | Acknowledge strobe for the current winner |
| intPending | output | 1 | An unmasked request is waiting |
| intNum | output | 3 | Number of the winning request |
| intVector | output | 8 | Vector base bits 7:3 followed by `intNum` |

## Verification
The in-RTL assertions check the following on every cycle: state transitions on the first word, on a restart and on the last initialization word; the mask load; the clearing done by a restart; that request bits never drop without an acknowledge; that a specific end of interrupt clears its bit; and that the in-service register is left alone by acknowledges in automatic mode. The number of initialization steps for each flag combination can only be shown by the bench's scenarios. The same holds for the read-back selection, the priority and vector results over every request pattern against several masks, and the end-of-interrupt sequences. Each of these is observed through the register port.

// File: rtl/picRegPkg.sv
package picRegPkg;

  typedef enum logic [2:0] {
    ST_WANT_FIRST,
    ST_WANT_BASE,
    ST_WANT_CASCADE,
    ST_WANT_MODE,
    ST_READY
  } initState_t;

  // one-cycle strobes from control to datapath
  typedef struct packed {
    logic startInit;
    logic takeBase;
    logic takeMode;
    logic loadMask;
    logic loadSelect;
    logic eoiLowest;
    logic eoiLevel;
  } strobe_t;

  // bit positions that the decode depends on
  localparam int FIRST_NEED_MODE = 0;
  localparam int FIRST_SINGLE    = 1;
  localparam int MODE_AUTO_EOI   = 1;
  localparam int CMD_KIND_LO     = 3;
  localparam int CMD_KIND_HI     = 4;
  localparam int CMD_EOI         = 5;
  localparam int CMD_SPECIFIC    = 6;

endpackage

// File: rtl/picRegCtrl.sv
module picRegCtrl
  import picRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic       regAddr,
  input  logic [3:0] cmdField,   // {specific, eoi, kindHi, kindLo}
  input  logic       firstSingle,
  input  logic       firstNeedMode,
  output strobe_t    strobes
);

  initState_t state, stateNext;

  logic kindLo, kindHi, eoiBit, specBit;
  assign kindLo  = cmdField[0];
  assign kindHi  = cmdField[1];
  assign eoiBit  = cmdField[2];
  assign specBit = cmdField[3];

  always_comb begin
    strobes   = '0;
    stateNext = state;
    if (wrEn) begin
      if (!regAddr) begin
        if (state == ST_WANT_FIRST || kindHi) begin
          strobes.startInit = 1'b1;
          stateNext         = ST_WANT_BASE;
        end else if (state == ST_READY) begin
          if (kindLo) begin
            strobes.loadSelect = 1'b1;
          end else if (eoiBit) begin
            strobes.eoiLowest = !specBit;
            strobes.eoiLevel  = specBit;
          end
        end
      end else begin
        case (state)
          ST_WANT_BASE: begin
            strobes.takeBase = 1'b1;
            if (!firstSingle)       stateNext = ST_WANT_CASCADE;
            else if (firstNeedMode) stateNext = ST_WANT_MODE;
            else                    stateNext = ST_READY;
          end
          ST_WANT_CASCADE: stateNext = firstNeedMode ? ST_WANT_MODE : ST_READY;
          ST_WANT_MODE: begin
            strobes.takeMode = 1'b1;
            stateNext        = ST_READY;
          end
          ST_READY: strobes.loadMask = 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_WANT_FIRST;
    else       state <= stateNext;
  end

  // R2: first command write always leads to the vector-base step
  a_r2_first_word: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WANT_FIRST && wrEn && !regAddr) |=> state == ST_WANT_BASE);

  // R12: restart from any state
  a_r12_restart_state: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && !regAddr && kindHi) |=> state == ST_WANT_BASE);

  // R3: single mode never visits the cascade step
  a_r3_single_skip: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WANT_BASE && wrEn && regAddr && firstSingle) |=> state != ST_WANT_CASCADE);

  // R4: mode word ends the sequence
  a_r4_mode_done: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_WANT_MODE && wrEn && regAddr) |=> state == ST_READY);

  // R6: operational commands keep the block ready
  a_r6_ready_hold: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READY && !(wrEn && !regAddr && kindHi)) |=> state == ST_READY);

endmodule

// File: rtl/picRegData.sv
module picRegData
  import picRegPkg::*;
#(
  parameter int DATA_W = 8,
  localparam int NUM_W = $clog2(DATA_W)
)(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobes,
  input  logic              regAddr,
  input  logic [DATA_W-1:0] wrData,
  input  logic [DATA_W-1:0] irqReq,
  input  logic              intAck,
  output logic              firstSingle,
  output logic              firstNeedMode,
  output logic [DATA_W-1:0] rdData,
  output logic              intPending,
  output logic [NUM_W-1:0]  intNum,
  output logic [DATA_W-1:0] intVector
);

  logic [DATA_W-1:0]       irr, isr, imr, activeReq, ackClear, isrNext;
  logic [DATA_W-NUM_W-1:0] vecBase;
  logic [1:0]              readSel;
  logic                    autoEoi, ackHit;

  function automatic logic [NUM_W-1:0] lowestSet(input logic [DATA_W-1:0] v);
    lowestSet = '0;
    for (int i = DATA_W - 1; i >= 0; i--)
      if (v[i]) lowestSet = i[NUM_W-1:0];
  endfunction

  assign activeReq  = irr & ~imr;
  assign intPending = |activeReq;
  assign intNum     = lowestSet(activeReq);
  assign intVector  = {vecBase, intNum};
  assign ackHit     = intAck && intPending;
  assign ackClear   = ackHit ? (DATA_W'(1) << intNum) : '0;

  always_comb begin
    isrNext = isr;
    if (strobes.eoiLowest) isrNext = isrNext & (isrNext - DATA_W'(1));
    if (strobes.eoiLevel)  isrNext[wrData[NUM_W-1:0]] = 1'b0;
    if (ackHit && !autoEoi) isrNext = isrNext | ackClear;
    if (strobes.startInit)  isrNext = '0;
  end

  always_comb begin
    if (regAddr)              rdData = imr;
    else if (readSel == 2'b10) rdData = irr;
    else if (readSel == 2'b11) rdData = isr;
    else                      rdData = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      irr           <= '0;
      isr           <= '0;
      imr           <= '0;
      vecBase       <= '0;
      firstSingle   <= 1'b0;
      firstNeedMode <= 1'b0;
      autoEoi       <= 1'b0;
      readSel       <= 2'b10;
    end else begin
      irr <= (irr & ~ackClear) | irqReq;
      isr <= isrNext;
      if (strobes.startInit) begin
        imr           <= '0;
        firstSingle   <= wrData[FIRST_SINGLE];
        firstNeedMode <= wrData[FIRST_NEED_MODE];
        autoEoi       <= 1'b0;
      end
      if (strobes.takeBase)   vecBase <= wrData[DATA_W-1:NUM_W];
      if (strobes.takeMode)   autoEoi <= wrData[MODE_AUTO_EOI];
      if (strobes.loadMask)   imr     <= wrData;
      if (strobes.loadSelect) readSel <= wrData[1:0];
    end
  end

  // R5: mask takes the written byte
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strobes.loadMask |=> imr == $past(wrData));

  // R12: restart empties mask and in-service
  a_r12_restart_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobes.startInit |=> (imr == '0 && isr == '0));

  // R8: request bits only drop through an acknowledge
  a_r8_irr_sticky: assert property (@(posedge clk) disable iff (!rstN)
    !intAck |=> ((irr & $past(irr)) == $past(irr)));

  // R11: specific end of interrupt clears the named bit
  a_r11_level_eoi: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.eoiLevel && !intAck) |=> !isr[$past(wrData[NUM_W-1:0])]);

  // R10: automatic mode leaves in-service alone on acknowledge
  a_r10_auto_ack: assert property (@(posedge clk) disable iff (!rstN)
    (intAck && autoEoi && strobes == '0) |=> $stable(isr));

endmodule

// File: rtl/picRegTop.sv
module picRegTop
  import picRegPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       regAddr,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  input  logic [7:0] irqReq,
  input  logic       intAck,
  output logic       intPending,
  output logic [2:0] intNum,
  output logic [7:0] intVector
);

  strobe_t    strobes;
  logic       firstSingle, firstNeedMode;
  logic [3:0] cmdField;

  assign cmdField = {wrData[CMD_SPECIFIC], wrData[CMD_EOI],
                     wrData[CMD_KIND_HI], wrData[CMD_KIND_LO]};

  picRegCtrl u_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .wrEn          (wrEn),
    .regAddr       (regAddr),
    .cmdField      (cmdField),
    .firstSingle   (firstSingle),
    .firstNeedMode (firstNeedMode),
    .strobes       (strobes)
  );

  picRegData #(.DATA_W(8)) u_data (
    .clk           (clk),
    .rstN          (rstN),
    .strobes       (strobes),
    .regAddr       (regAddr),
    .wrData        (wrData),
    .irqReq        (irqReq),
    .intAck        (intAck),
    .firstSingle   (firstSingle),
    .firstNeedMode (firstNeedMode),
    .rdData        (rdData),
    .intPending    (intPending),
    .intNum        (intNum),
    .intVector     (intVector)
  );

endmodule

// File: tb/picRegTop_bench.sv
`timescale 1ns/1ps
module picRegTop_bench;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regAddr = 1'b0;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = '0;
  logic [7:0] irqReq = '0;
  logic       intAck = 1'b0;
  logic [7:0] rdData, intVector;
  logic       intPending;
  logic [2:0] intNum;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  picRegTop u_picRegTop (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .irqReq(irqReq), .intAck(intAck), .intPending(intPending),
    .intNum(intNum), .intVector(intVector)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk);
    regAddr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [7:0] v);
    regAddr = a;
    #1;
    v = rdData;
  endtask

  task automatic ack();
    @(negedge clk);
    intAck = 1'b1;
    @(negedge clk);
    intAck = 1'b0;
  endtask

  task automatic pulse(input logic [7:0] r);
    @(negedge clk);
    irqReq = r;
    @(negedge clk);
    irqReq = '0;
  endtask

  function automatic int lowBit(input logic [7:0] v);
    for (int i = 0; i < 8; i++) if (v[i]) return i;
    return 0;
  endfunction

  initial begin
    #750000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [7:0] masks [3];
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, v); check("R1 cmd read", v, 0);
    rd(1'b1, v); check("R1 mask read", v, 0);
    check("R1 pending", intPending, 0);

    // R2 data write ignored before first word
    wr(1'b1, 8'h55);
    rd(1'b1, v); check("R2 data ignored", v, 0);

    // R3 R4 step count for each flag pair; R12 restart clears mask
    for (int cfg = 0; cfg < 4; cfg++) begin
      int extra;
      wr(1'b0, 8'h10 | 8'(cfg));
      rd(1'b1, v); check("R12 restart clears mask", v, 0);
      wr(1'b1, 8'h20);
      extra = ((cfg & 2) ? 0 : 1) + ((cfg & 1) ? 1 : 0);
      for (int k = 0; k < extra; k++) begin
        wr(1'b1, 8'h00);
        rd(1'b1, v); check("R3 R4 word consumed, not mask", v, 0);
      end
      wr(1'b1, 8'h3C);
      rd(1'b1, v); check("R3 R4 ready after steps", v, 8'h3C);
    end

    // auto-EOI config, vector base 0xA8
    wr(1'b0, 8'h13); wr(1'b1, 8'hA8); wr(1'b1, 8'h02);

    // R8 R9 R10 sweep over all request patterns
    for (int r = 0; r < 256; r++) begin
      masks[0] = 8'h00; masks[1] = 8'(r) ^ 8'hA5; masks[2] = 8'hF0;
      for (int mi = 0; mi < 3; mi++) begin
        logic [7:0] act;
        wr(1'b1, 8'h00);
        for (int k = 0; k < 9; k++) if (intPending) ack();
        check("R10 drained by acks", intPending, 0);
        pulse(8'(r));
        wr(1'b1, masks[mi]);
        rd(1'b0, v); check("R8 request held", v, r);
        act = 8'(r) & ~masks[mi];
        check("R8 pending", intPending, (act != 0) ? 1 : 0);
        check("R9 number", intNum, lowBit(act));
        check("R9 vector", intVector, 8'hA8 | lowBit(act));
      end
    end
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R10 auto mode in-service empty", v, 0);
    wr(1'b0, 8'h0A);

    // R12 restart keeps requests (0xFF left pending) and read select
    wr(1'b0, 8'h11);
    rd(1'b0, v); check("R12 requests kept", v, 8'hFF);
    wr(1'b1, 8'h40); wr(1'b1, 8'h04); wr(1'b1, 8'h00);

    // R10 acknowledge moves to in-service
    ack();
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R10 in-service set", v, 8'h01);
    check("R9 vector base 0x40", intVector, 8'h41);
    wr(1'b0, 8'h0A);
    rd(1'b0, v); check("R10 request cleared", v, 8'hFE);
    repeat (7) ack();
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R10 all in service", v, 8'hFF);
    ack();
    rd(1'b0, v); check("R10 ack without pending", v, 8'hFF);

    // R11 end-of-interrupt forms
    wr(1'b0, 8'h20); rd(1'b0, v); check("R11 lowest cleared", v, 8'hFE);
    wr(1'b0, 8'h65); rd(1'b0, v); check("R11 level 5 cleared", v, 8'hDE);
    wr(1'b0, 8'h45); rd(1'b0, v); check("R11 no eoi bit", v, 8'hDE);
    wr(1'b0, 8'h65); rd(1'b0, v); check("R11 level repeat", v, 8'hDE);
    wr(1'b0, 8'h20); rd(1'b0, v); check("R11 lowest again", v, 8'hDC);

    // R7 read select variants
    wr(1'b0, 8'h08); rd(1'b0, v); check("R7 select 00", v, 0);
    wr(1'b0, 8'h09); rd(1'b0, v); check("R7 select 01", v, 0);

    // R6 commands leave mask; R5 mask read
    wr(1'b1, 8'h81);
    wr(1'b0, 8'h0B); rd(1'b1, v); check("R6 select keeps mask", v, 8'h81);
    wr(1'b0, 8'h20); rd(1'b1, v); check("R6 eoi keeps mask", v, 8'h81);
    rd(1'b0, v); check("R6 eoi decoded", v, 8'hD8);

    // R12 restart mid-sequence, ignored command, in-service cleared
    wr(1'b0, 8'h12);
    wr(1'b0, 8'h0A);
    wr(1'b1, 8'h50);
    wr(1'b1, 8'h66);
    rd(1'b1, v); check("R12 ignored command mid-init", v, 8'h66);
    wr(1'b0, 8'h0B);
    rd(1'b0, v); check("R12 in-service cleared", v, 0);
    pulse(8'h80);
    check("R9 vector after restart", intVector, 8'h57);
    check("R8 pending unmasked 7", intPending, 1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule